// File: doc/BRIEF.md
# Burst-Capable External Bus Cycle Sequencer

This block is the master side of an external memory bus. It accepts an internal request for either a single 32-bit longword or a 16-byte line and turns it into bus cycles. It drives the byte address, the read/write line, a two-bit transfer-size code, a start strobe, an in-progress flag, an address strobe that doubles as the chip-select enable, an output enable and a byte write enable. Each beat ends either after a counted number of wait states or on a sampled acknowledge from the target.

A line moves as four longword beats. It runs either as a true burst, with one start strobe and a 3-2-2-2 clock shape, or as four separate transfers: one basic cycle followed by three fast cycles. A longword read from an 8-bit device runs as one burst of four byte beats. The bytes are packed most significant first into a 32-bit result. The size code never changes inside a request.

A request is taken only while the block is idle. The termination choice and the wait-state count are captured with the request. A one-clock done pulse follows the last beat, and the next request may be taken in that same clock.

Top module: `burst_bus_seq`

## Requirements
- R1: `reqReady` is high exactly while the block is idle. A request is accepted when `reqValid` is high in an idle clock, and the start strobe appears in the next clock. `reqValid` and every request or configuration input are ignored while a request is running.
- R2: The first beat of every request lasts 3 clocks plus the wait-state count under internal termination.
- R3: Every later beat lasts 2 clocks plus the wait-state count under internal termination. This holds for burst beats and for fast burst-inhibited beats alike.
- R4: With `extTerm` captured high, a beat ends in the clock in which `ackIn` is sampled high. That clock can be no earlier than the beat's last minimum clock, and `ackIn` is ignored in the clocks before it. With `extTerm` captured low, `ackIn` has no effect.
- R5: For a line, `busAddr` is the request address with bits [3:0] replaced by {beat, 2'b00}, beat stepping 0,1,2,3. For a packed byte read it is the request address with bits [1:0] replaced by the beat. For a single longword it is the request address with bits [1:0] cleared.
- R6: `busSize` is 2'b11 for a burst line and 2'b00 for every other request, and it stays constant from the first clock to the last clock of the request.
- R7: `busTs` is high only in the first clock of each transfer. A burst line and a packed byte read have one such clock. A burst-inhibited line has one at the start of every beat.
- R8: `busTip` and `busAs` are high from the first clock of a request through the last clock of its final beat, and low when idle.
- R9: While a request runs, `busOe` is high for reads, `busBwe` is high for writes, and `busRnw` is 0 only for writes. All three enables are inactive when idle.
- R10: A packed byte read takes each byte from `busDataIn[31:24]` and returns {byte0, byte1, byte2, byte3}. `reqPort8` is ignored for writes, which run as one longword, and for line requests.
- R11: `rdValid` pulses one clock after each read beat of a line, and one clock after the only or the last beat of any other read, carrying the captured data. `done` pulses for exactly one clock after the final beat, and `busTip` falls in that same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | 32 | Byte address of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLine | input | 1 | 1 = 16-byte line, 0 = longword |
| reqBurst | input | 1 | Line as true burst (1) or burst-inhibited (0) |
| reqPort8 | input | 1 | Longword read from an 8-bit device |
| extTerm | input | 1 | 1 = end beats on acknowledge, 0 = counted wait states |
| waitStates | input | 4 | Wait states added to every beat under internal termination |
| ackIn | input | 1 | Transfer acknowledge from the target |
| busDataIn | input | 32 | Read data from the bus |
| reqReady | output | 1 | Idle and able to accept a request |
| busAddr | output | 32 | Bus address |
| busRnw | output | 1 | 1 = read, 0 = write |
| busSize | output | 2 | Transfer size code |
| busTs | output | 1 | Transfer start strobe |
| busTip | output | 1 | Transfer in progress |
| busAs | output | 1 | Address strobe / chip-select enable |
| busOe | output | 1 | Output enable for reads |
| busBwe | output | 1 | Byte write enable for writes |
| rdValid | output | 1 | Read result valid pulse |
| rdData | output | 32 | Read result |
| done | output | 1 | Request finished pulse |

## Verification
The done pulse of one request and the acceptance of the next can fall in the same clock. The sweep runs every mode, direction, termination choice and wait-state count back to back, so each request is presented in the very clock where the previous one reports done. The bench then checks that the start strobe of the new request appears one clock later with its own address and size, and that the old read result is still on `rdData` in the done clock. Some runs also toggle `reqValid` and the configuration inputs while a request is busy, and `ackIn` is held high whenever it must be ignored. Every beat length, address step and strobe is compared clock by clock with the shape computed in the bench.

// File: rtl/burst_bus_seq_pkg.sv
package burst_bus_seq_pkg;

  typedef enum logic [1:0] {
    MODE_LONG       = 2'd0,
    MODE_LINE_BURST = 2'd1,
    MODE_LINE_INH   = 2'd2,
    MODE_PORT8      = 2'd3
  } xferMode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_TERM = 2'd2
  } phase_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_LINE = 2'b11;

  typedef struct packed {
    logic load;     // request accepted this clock
    logic beatEnd;  // current beat terminates this clock
    logic lastEnd;  // final beat terminates this clock
  } seqStrobe_t;

endpackage

// File: rtl/burst_bus_seq_ctrl.sv
module burst_bus_seq_ctrl
  import burst_bus_seq_pkg::*;
#(
  parameter int WS_W       = 4,
  parameter int BASE_FIRST = 3,
  parameter int BASE_NEXT  = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic            reqLine,
  input  logic            reqBurst,
  input  logic            reqPort8,
  input  logic            extTerm,
  input  logic [WS_W-1:0] waitStates,
  input  logic            ackIn,
  input  logic            lastBeat,
  output seqStrobe_t      strobe,
  output xferMode_e       mode,
  output logic            isWrite,
  output logic            busy,
  output logic            tsOut,
  output logic            doneOut
);

  localparam int LW = (BASE_FIRST > 2) ? $clog2(BASE_FIRST) : 1;
  localparam logic [LW-1:0] LEAD_FIRST = LW'(BASE_FIRST - 2);
  localparam logic [LW-1:0] LEAD_NEXT  = LW'(BASE_NEXT - 2);

  phase_e          phase;
  logic [LW-1:0]   leadCnt;
  logic [WS_W-1:0] waitCnt;
  logic [WS_W-1:0] wsReg;
  logic            extReg;
  logic            tsReg;
  logic            doneReg;
  xferMode_e       modeReg;
  xferMode_e       reqMode;
  logic            accept;
  logic            termNow;

  always_comb begin
    if (reqLine)                   reqMode = reqBurst ? MODE_LINE_BURST : MODE_LINE_INH;
    else if (reqPort8 && !reqWrite) reqMode = MODE_PORT8;
    else                           reqMode = MODE_LONG;
  end

  assign accept  = reqValid && (phase == PH_IDLE);
  assign termNow = (phase == PH_TERM) && (extReg ? ackIn : (waitCnt == wsReg));

  assign strobe.load    = accept;
  assign strobe.beatEnd = termNow;
  assign strobe.lastEnd = termNow && lastBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      leadCnt <= '0;
      waitCnt <= '0;
      wsReg   <= '0;
      extReg  <= 1'b0;
      tsReg   <= 1'b0;
      doneReg <= 1'b0;
      modeReg <= MODE_LONG;
      isWrite <= 1'b0;
    end else begin
      tsReg   <= 1'b0;
      doneReg <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase   <= PH_LEAD;
            leadCnt <= LEAD_FIRST;
            modeReg <= reqMode;
            isWrite <= reqWrite;
            wsReg   <= waitStates;
            extReg  <= extTerm;
            tsReg   <= 1'b1;
          end
        end
        PH_LEAD: begin
          if (leadCnt == '0) begin
            phase   <= PH_TERM;
            waitCnt <= '0;
          end else begin
            leadCnt <= leadCnt - 1'b1;
          end
        end
        PH_TERM: begin
          if (termNow) begin
            if (lastBeat) begin
              phase   <= PH_IDLE;
              doneReg <= 1'b1;
            end else begin
              phase   <= PH_LEAD;
              leadCnt <= LEAD_NEXT;
              tsReg   <= (modeReg == MODE_LINE_INH);
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign mode    = modeReg;
  assign busy    = (phase != PH_IDLE);
  assign tsOut   = tsReg;
  assign doneOut = doneReg;

endmodule

// File: rtl/burst_bus_seq_dpath.sv
module burst_bus_seq_dpath
  import burst_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  xferMode_e         mode,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int BEAT_W = $clog2(BEATS);
  localparam int LANE_W = DATA_W / BEATS;
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;

  assign lastBeat = (mode == MODE_LONG) || (beatCnt == LAST_IDX);

  always_comb begin
    case (mode)
      MODE_LINE_BURST, MODE_LINE_INH:
        busAddr = {baseAddr[ADDR_W-1:BEAT_W+2], beatCnt, 2'b00};
      MODE_PORT8:
        busAddr = {baseAddr[ADDR_W-1:BEAT_W], beatCnt};
      default:
        busAddr = {baseAddr[ADDR_W-1:2], 2'b00};
    endcase
  end

  assign busSize = (mode == MODE_LINE_BURST) ? SZ_LINE : SZ_LONG;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      rdValid <= strobe.beatEnd && !isWrite && ((mode != MODE_PORT8) || lastBeat);
      if (strobe.load) begin
        baseAddr <= reqAddr;
        beatCnt  <= '0;
      end else if (strobe.beatEnd) begin
        beatCnt <= strobe.lastEnd ? '0 : beatCnt + 1'b1;
      end
      if (strobe.beatEnd && !isWrite) begin
        if (mode == MODE_PORT8)
          rdData <= {rdData[DATA_W-LANE_W-1:0], busDataIn[DATA_W-1 -: LANE_W]};
        else
          rdData <= busDataIn;
      end
    end
  end

endmodule

// File: rtl/burst_bus_seq.sv
module burst_bus_seq
  import burst_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqLine,
  input  logic              reqBurst,
  input  logic              reqPort8,
  input  logic              extTerm,
  input  logic [WS_W-1:0]   waitStates,
  input  logic              ackIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              reqReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRnw,
  output logic [1:0]        busSize,
  output logic              busTs,
  output logic              busTip,
  output logic              busAs,
  output logic              busOe,
  output logic              busBwe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  seqStrobe_t strobe;
  xferMode_e  mode;
  logic       isWrite;
  logic       busy;
  logic       lastBeat;

  burst_bus_seq_ctrl #(
    .WS_W(WS_W), .BASE_FIRST(3), .BASE_NEXT(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLine(reqLine), .reqBurst(reqBurst), .reqPort8(reqPort8),
    .extTerm(extTerm), .waitStates(waitStates), .ackIn(ackIn),
    .lastBeat(lastBeat), .strobe(strobe), .mode(mode), .isWrite(isWrite),
    .busy(busy), .tsOut(busTs), .doneOut(done)
  );

  burst_bus_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(4)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .isWrite(isWrite),
    .reqAddr(reqAddr), .busDataIn(busDataIn), .lastBeat(lastBeat),
    .busAddr(busAddr), .busSize(busSize), .rdValid(rdValid), .rdData(rdData)
  );

  assign reqReady = !busy;
  assign busTip   = busy;
  assign busAs    = busy;
  assign busOe    = busy && !isWrite;
  assign busBwe   = busy && isWrite;
  assign busRnw   = !(busy && isWrite);

endmodule

// File: rtl/burst_bus_seq_chk.sv
module burst_bus_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              busTs,
  input logic              busTip,
  input logic [1:0]        busSize,
  input logic [ADDR_W-1:0] busAddr,
  input logic              done
);

  // R1
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> busTs);

  // R7
  ts_within_tip_chk: assert property (@(posedge clk) disable iff (!rstN)
    busTs |-> busTip);

  // R6
  size_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busTip && $past(busTip) |-> $stable(busSize));

  // R5
  line_base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busTip && !busTs |-> $stable(busAddr[ADDR_W-1:4]));

  // R11
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busTip) |-> done);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind burst_bus_seq burst_bus_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busTs(busTs), .busTip(busTip), .busSize(busSize), .busAddr(busAddr),
  .done(done)
);

// File: tb/burst_bus_seq_test.sv
module burst_bus_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqLine = 1'b0;
  logic        reqBurst = 1'b0;
  logic        reqPort8 = 1'b0;
  logic        extTerm = 1'b0;
  logic [3:0]  waitStates = '0;
  logic        ackIn = 1'b0;
  logic [31:0] busDataIn = '0;
  logic        reqReady, busRnw, busTs, busTip, busAs, busOe, busBwe, rdValid, done;
  logic [31:0] busAddr, rdData;
  logic [1:0]  busSize;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  burst_bus_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLine(reqLine), .reqBurst(reqBurst),
    .reqPort8(reqPort8), .extTerm(extTerm), .waitStates(waitStates),
    .ackIn(ackIn), .busDataIn(busDataIn), .reqReady(reqReady),
    .busAddr(busAddr), .busRnw(busRnw), .busSize(busSize), .busTs(busTs),
    .busTip(busTip), .busAs(busAs), .busOe(busOe), .busBwe(busBwe),
    .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int op, input int b);
    return {8'(op * 7 + b * 17 + 1), 8'(b), 8'hA5, 8'(op)};
  endfunction

  // md: 0 longword, 1 burst line, 2 inhibited line, 3 packed byte read
  task automatic runOp(input int op, input int md, input bit wr, input bit ext,
                       input int ws, input bit noise);
    int em, nb, base, len, d;
    logic [31:0] a, expA, packed32;
    bit isRead;
    em = (md == 3 && wr) ? 0 : md;
    nb = (em == 0) ? 1 : 4;
    isRead = !wr;
    a = 32'h4A6C_0000 + op * 32'h1357;
    packed32 = '0;
    chk("R1 ready when idle", {31'd0, reqReady}, 32'd1);
    reqValid   = 1'b1;
    reqAddr    = a;
    reqWrite   = wr;
    reqLine    = (md == 1 || md == 2);
    reqBurst   = (md == 1);
    reqPort8   = (md == 3) || (md != 0 && op[0]);
    extTerm    = ext;
    waitStates = 4'(ws);
    @(posedge clk); @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      base = (b == 0) ? 3 : 2;
      d = (ws + b) % 3;
      len = base + (ext ? d : ws);
      if (em == 1 || em == 2) expA = {a[31:4], 2'(b), 2'b00};
      else if (em == 3)       expA = {a[31:2], 2'(b)};
      else                    expA = {a[31:2], 2'b00};
      for (int c = 0; c < len; c++) begin
        reqValid = noise;
        if (noise) begin
          waitStates = ~4'(ws);
          extTerm    = !ext;
          reqWrite   = !wr;
          reqLine    = !reqLine;
          reqAddr    = ~a;
        end
        busDataIn = pat(op, b);
        ackIn = ext ? ((c < base - 1) || (c == len - 1)) : 1'b1;
        chk(b == 0 ? "R2 tip/as in beat" : "R3 tip/as in beat", {30'd0, busTip, busAs}, 32'd3);
        chk("R8 ready low while busy", {31'd0, reqReady}, 32'd0);
        chk("R7 start strobe", {31'd0, busTs}, {31'd0, (c == 0 && (b == 0 || em == 2))});
        chk("R5 address", busAddr, expA);
        chk("R6 size", {30'd0, busSize}, (em == 1) ? 32'd3 : 32'd0);
        chk("R9 enables", {29'd0, busOe, busBwe, busRnw}, isRead ? 32'd5 : 32'd2);
        chk(ext ? "R4 no early done" : "R11 no early done", {31'd0, done}, 32'd0);
        if (c == 0 && b > 0 && isRead && em != 3) begin
          chk("R11 line beat valid", {31'd0, rdValid}, 32'd1);
          chk("R11 line beat data", rdData, pat(op, b - 1));
        end else begin
          chk("R11 no stray valid", {31'd0, rdValid}, 32'd0);
        end
        @(posedge clk); @(negedge clk);
      end
      packed32 = {packed32[23:0], pat(op, b)[31:24]};
    end
    reqValid = 1'b0;
    ackIn = 1'b0;
    chk("R11 done pulse", {31'd0, done}, 32'd1);
    chk("R8 tip falls", {30'd0, busTip, busAs}, 32'd0);
    chk("R9 idle enables", {29'd0, busOe, busBwe, busRnw}, 32'd1);
    if (isRead) begin
      chk("R11 final valid", {31'd0, rdValid}, 32'd1);
      chk(em == 3 ? "R10 packed bytes" : "R11 final data", rdData,
          em == 3 ? packed32 : pat(op, nb - 1));
    end else begin
      chk("R10 write valid stays low", {31'd0, rdValid}, 32'd0);
    end
  endtask

  initial begin
    int op;
    op = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset tip", {30'd0, busTip, busAs}, 32'd0);
    chk("R7 reset ts", {31'd0, busTs}, 32'd0);
    chk("R1 reset ready", {31'd0, reqReady}, 32'd1);
    chk("R11 reset done", {30'd0, done, rdValid}, 32'd0);
    chk("R9 reset enables", {29'd0, busOe, busBwe, busRnw}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    for (int md = 0; md < 4; md++)
      for (int wr = 0; wr < 2; wr++)
        for (int ext = 0; ext < 2; ext++)
          for (int ws = 0; ws < 4; ws++) begin
            runOp(op, md, wr[0], ext[0], ws, (op % 5) == 2);
            op++;
          end
    @(posedge clk); @(negedge clk);
    chk("R11 done single pulse", {31'd0, done}, 32'd0);
    chk("R8 idle after sweep", {31'd0, busTip}, 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule